// File: doc/BRIEF.md
# Voltage-Code Change Transition Timer

This block watches a 5-bit voltage-identification code supplied by a processor and decides when the code has really changed. Each input bit first passes through a two-stage synchronizer. A differing value must then stay unchanged for longer than a programmable settling window before the block accepts it. Shorter disturbances leave the block's state alone.

When a change is accepted, the block latches the new code as its reference and publishes it on its code output. It also starts a long, fixed-length transition interval. Throughout that interval it raises five control flags used by the surrounding regulator logic:

- a mask that suppresses over- and under-voltage fault handling;
- an over-voltage indicator pin, which is driven high so that it can also switch in a lower current-limit setting;
- a pull-down request for the power-good output;
- a disable for the zero-current low-side turn-off;
- an enable for the negative current limit.

A further accepted change during the interval starts the interval again from zero. Driving the enable input low stops all of this activity.

Both windows are parameters counted in clock cycles. With a 100 MHz clock the defaults correspond to 200 ns of settling and 100 µs of transition.

Top module: `vid_transition_timer`

## Requirements
- R1: After synchronous reset, code_q is 5'b00000 and every flag output (trans_active, prot_mask, ovp_flag, pgood_pulldown, zc_disable, neg_ilim_en) is low.
- R2: vid_in bit 0 is the least significant bit. A new value presented at vid_in, held for GLITCH_CYC+1 consecutive rising edges or more while enable is high, is accepted. code_q takes it and trans_active rises on the (GLITCH_CYC+3)-th rising edge counted from the first edge that samples it, and not earlier.
- R3: A value that differs from code_q but is held for GLITCH_CYC edges or fewer before vid_in returns to code_q leaves code_q and all flags unchanged.
- R4: If vid_in moves from one non-reference value to another, the settling count restarts. Two back-to-back disturbances of GLITCH_CYC edges each are both ignored.
- R5: code_q changes only on the edge at which a transition interval starts, and never while enable is high outside such an edge.
- R6: Each transition interval keeps trans_active high for exactly TRANS_CYC clock cycles after its starting edge.
- R7: A change accepted while an interval is running restarts the interval, so trans_active stays high for TRANS_CYC cycles after the newest accepted change.
- R8: All flags are active high. prot_mask, ovp_flag, pgood_pulldown, zc_disable and neg_ilim_en are each high exactly when trans_active is high.
- R9: While enable is low, the next edge clears trans_active and all flags, and code_q follows the synchronized vid_in (three edges after vid_in changes). Raising enable again starts no transition when vid_in matches code_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable (high = operate, low = shut down) |
| vid_in | input | 5 | Asynchronous voltage-identification code, bit 0 LSB |
| code_q | output | 5 | Qualified, latched code |
| trans_active | output | 1 | Transition interval in progress |
| prot_mask | output | 1 | Suppress output fault handling |
| ovp_flag | output | 1 | Over-voltage indicator pin, high during transition |
| pgood_pulldown | output | 1 | Pull power-good low |
| zc_disable | output | 1 | Disable zero-current low-side turn-off |
| neg_ilim_en | output | 1 | Enable negative current limit |

## Verification
A settling counter that fails to restart on a new candidate would accept a burst of short disturbances. That shows on code_q and trans_active within about two settling windows. An off-by-one in either counter moves the edge where trans_active rises or falls by one cycle, so the bench samples one cycle on each side of both edges. A reference register that does not reload while enable is low causes a spurious transition on the first settling window after enable returns.

// File: rtl/vtt_pkg.sv
package vtt_pkg;
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  function automatic logic settled(input int unsigned seen, input int unsigned need);
    return seen >= need;
  endfunction

  function automatic logic window_end(input int unsigned elapsed, input int unsigned len);
    return elapsed + 1 >= len;
  endfunction
endpackage

// File: rtl/vtt_sync.sv
module vtt_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stg1;
  logic [W-1:0] stg2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1 <= '0;
      stg2 <= '0;
    end else begin
      stg1 <= d_async;
      stg2 <= stg1;
    end
  end

  assign d_sync = stg2;
endmodule

// File: rtl/vtt_qualifier.sv
module vtt_qualifier
  import vtt_pkg::*;
#(
  parameter int W          = 5,
  parameter int GLITCH_CYC = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] ref_code,
  output logic         accept
);
  localparam int GW = cnt_bits(GLITCH_CYC);

  logic [W-1:0]  cand;
  logic [GW-1:0] seen;
  logic          differs;
  logic          same_cand;

  assign differs   = (code_in != ref_code);
  assign same_cand = (code_in == cand);
  assign accept    = enable && differs && same_cand &&
                     settled(int'(seen), GLITCH_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_code <= '0;
      cand     <= '0;
      seen     <= '0;
    end else if (!enable) begin
      ref_code <= code_in;
      cand     <= code_in;
      seen     <= '0;
    end else if (!differs) begin
      seen     <= '0;
      cand     <= code_in;
    end else if (accept) begin
      ref_code <= code_in;
      seen     <= '0;
    end else if (!same_cand) begin
      cand     <= code_in;
      seen     <= GW'(1);
    end else begin
      seen     <= seen + GW'(1);
    end
  end
endmodule

// File: rtl/vtt_timer.sv
module vtt_timer
  import vtt_pkg::*;
#(
  parameter int TRANS_CYC = 10000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           enable,
  input  logic                           start,
  output logic                           active,
  output logic [cnt_bits(TRANS_CYC)-1:0] elapsed
);
  localparam int TW = cnt_bits(TRANS_CYC);

  logic last_cycle;
  assign last_cycle = window_end(int'(elapsed), TRANS_CYC);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      active  <= 1'b0;
      elapsed <= '0;
    end else if (start) begin
      active  <= 1'b1;
      elapsed <= '0;
    end else if (active) begin
      if (last_cycle) begin
        active  <= 1'b0;
        elapsed <= '0;
      end else begin
        elapsed <= elapsed + TW'(1);
      end
    end
  end
endmodule

// File: rtl/vid_transition_timer.sv
module vid_transition_timer
  import vtt_pkg::*;
#(
  parameter int VID_W      = 5,
  parameter int GLITCH_CYC = 20,
  parameter int TRANS_CYC  = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [VID_W-1:0] vid_in,
  output logic [VID_W-1:0] code_q,
  output logic             trans_active,
  output logic             prot_mask,
  output logic             ovp_flag,
  output logic             pgood_pulldown,
  output logic             zc_disable,
  output logic             neg_ilim_en
);
  localparam int TW = cnt_bits(TRANS_CYC);

  logic [VID_W-1:0] vid_sync;
  logic             chg_accept;
  logic [TW-1:0]    tmr_cnt;
  logic             tmr_active;

  vtt_sync #(.W(VID_W)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (vid_in),
    .d_sync  (vid_sync)
  );

  vtt_qualifier #(.W(VID_W), .GLITCH_CYC(GLITCH_CYC)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .code_in  (vid_sync),
    .ref_code (code_q),
    .accept   (chg_accept)
  );

  vtt_timer #(.TRANS_CYC(TRANS_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .start   (chg_accept),
    .active  (tmr_active),
    .elapsed (tmr_cnt)
  );

  assign trans_active   = tmr_active;
  assign prot_mask      = tmr_active;
  assign ovp_flag       = tmr_active;
  assign pgood_pulldown = tmr_active;
  assign zc_disable     = tmr_active;
  assign neg_ilim_en    = tmr_active;
endmodule

// File: rtl/vtt_checker.sv
module vtt_checker #(
  parameter int VID_W     = 5,
  parameter int TRANS_CYC = 10000,
  parameter int TW        = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [VID_W-1:0] vid_sync,
  input logic [VID_W-1:0] code_q,
  input logic             chg_accept,
  input logic [TW-1:0]    tmr_cnt,
  input logic             trans_active,
  input logic             prot_mask,
  input logic             ovp_flag,
  input logic             pgood_pulldown
);
  AST_CODE_MOVES_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(enable) && !$stable(code_q)) |-> $past(chg_accept)); // R5

  AST_ACCEPT_OPENS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    chg_accept |=> (trans_active && code_q == $past(vid_sync))); // R7

  AST_ACCEPT_SEES_STABLE: assert property (@(posedge clk) disable iff (rst)
    (chg_accept && !$past(rst)) |-> (vid_sync == $past(vid_sync))); // R3

  AST_SHUTDOWN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!trans_active && !prot_mask && !ovp_flag && !pgood_pulldown)); // R9

  AST_WINDOW_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(trans_active) && !$past(rst) && $past(enable))
      |-> ($past(tmr_cnt) == TW'(TRANS_CYC - 1))); // R6
endmodule

bind vid_transition_timer vtt_checker #(
  .VID_W(VID_W), .TRANS_CYC(TRANS_CYC), .TW(TW)
) u_vtt_chk (
  .clk            (clk),
  .rst            (rst),
  .enable         (enable),
  .vid_sync       (vid_sync),
  .code_q         (code_q),
  .chg_accept     (chg_accept),
  .tmr_cnt        (tmr_cnt),
  .trans_active   (trans_active),
  .prot_mask      (prot_mask),
  .ovp_flag       (ovp_flag),
  .pgood_pulldown (pgood_pulldown)
);

// File: tb/test_vid_transition_timer.sv
module test_vid_transition_timer;
  localparam int G  = 4;
  localparam int T  = 40;
  localparam int LAT = G + 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [4:0] vid_in = '0;
  logic [4:0] code_q;
  logic trans_active, prot_mask, ovp_flag, pgood_pulldown, zc_disable, neg_ilim_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vid_transition_timer #(.VID_W(5), .GLITCH_CYC(G), .TRANS_CYC(T)) i_vid_transition_timer (
    .clk(clk), .rst(rst), .enable(enable), .vid_in(vid_in), .code_q(code_q),
    .trans_active(trans_active), .prot_mask(prot_mask), .ovp_flag(ovp_flag),
    .pgood_pulldown(pgood_pulldown), .zc_disable(zc_disable), .neg_ilim_en(neg_ilim_en)
  );

  typedef struct packed {
    logic [4:0] vid;
    logic [7:0] hold;
    logic       act;
    logic [4:0] code;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TAB [NV] = '{
    '{5'h00, 8'd3,  1'b0, 5'h1F},   // R2 one edge before acceptance
    '{5'h00, 8'd4,  1'b1, 5'h00},   // R2 accepted at edge G+3
    '{5'h00, 8'd40, 1'b0, 5'h00},   // R6 window over
    '{5'h15, 8'd7,  1'b1, 5'h15},   // R2
    '{5'h15, 8'd40, 1'b0, 5'h15},   // R6
    '{5'h0A, 8'd6,  1'b0, 5'h15},   // R2 not yet
    '{5'h0A, 8'd1,  1'b1, 5'h0A},   // R5 code and window together
    '{5'h0A, 8'd40, 1'b0, 5'h0A},   // R6
    '{5'h01, 8'd4,  1'b0, 5'h0A},   // R3 glitch of G edges
    '{5'h0A, 8'd10, 1'b0, 5'h0A},   // R3 ignored
    '{5'h02, 8'd4,  1'b0, 5'h0A},   // R4 first disturbance
    '{5'h03, 8'd4,  1'b0, 5'h0A}    // R4 second disturbance restarts count
  };

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_state(input string req, input logic exp_act, input logic [4:0] exp_code);
    logic [5:0] flags;
    flags = {trans_active, prot_mask, ovp_flag, pgood_pulldown, zc_disable, neg_ilim_en};
    checks++;
    if (code_q !== exp_code || flags !== {6{exp_act}}) begin
      errors++;
      $display("FAIL %s code=%h flags=%b expected code=%h flags=%b",
               req, code_q, flags, exp_code, {6{exp_act}});
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    check_state("R1", 1'b0, 5'h00);
    rst = 1'b0;

    // R9: disabled, code follows synchronized input after three edges
    vid_in = 5'h0A;
    wait_cyc(2);
    check_state("R9", 1'b0, 5'h00);
    wait_cyc(1);
    check_state("R9", 1'b0, 5'h0A);
    enable = 1'b1;

    // R2 latency boundary and R6 exact length
    vid_in = 5'h11;
    wait_cyc(LAT - 1);
    check_state("R2", 1'b0, 5'h0A);
    wait_cyc(1);
    check_state("R2", 1'b1, 5'h11);
    wait_cyc(T - 1);
    check_state("R6", 1'b1, 5'h11);
    wait_cyc(1);
    check_state("R6", 1'b0, 5'h11);

    // R7 retrigger
    vid_in = 5'h12;
    wait_cyc(LAT);
    check_state("R7", 1'b1, 5'h12);
    wait_cyc(20);
    vid_in = 5'h13;
    wait_cyc(LAT);
    check_state("R7", 1'b1, 5'h13);
    wait_cyc(T - 1);
    check_state("R7", 1'b1, 5'h13);
    wait_cyc(1);
    check_state("R7", 1'b0, 5'h13);

    // R9 shutdown during a transition
    vid_in = 5'h05;
    wait_cyc(LAT);
    check_state("R8", 1'b1, 5'h05);
    enable = 1'b0;
    wait_cyc(1);
    check_state("R9", 1'b0, 5'h05);
    vid_in = 5'h1F;
    wait_cyc(3);
    check_state("R9", 1'b0, 5'h1F);
    enable = 1'b1;
    wait_cyc(12);
    check_state("R9", 1'b0, 5'h1F);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      vid_in = TAB[k].vid;
      wait_cyc(int'(TAB[k].hold));
      check_state($sformatf("R2/R3/R4/R6 vec%0d", k), TAB[k].act, TAB[k].code);
    end
    vid_in = 5'h0A;
    wait_cyc(12);
    check_state("R4", 1'b0, 5'h0A);

    // R1 reset mid-transition
    vid_in = 5'h07;
    wait_cyc(LAT);
    check_state("R8", 1'b1, 5'h07);
    rst = 1'b1;
    vid_in = 5'h00;
    wait_cyc(1);
    check_state("R1", 1'b0, 5'h00);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule